// File: doc/BRIEF.md
# Work Queue Submission Portal

This block sits behind a memory-mapped submission window and decides, for every incoming 64-byte descriptor write, whether it enters a bounded first-in first-out work queue. Each write arrives in one cycle as one whole 512-bit descriptor. It carries an address and a flag that tells whether the submitter waits for an answer. A processing engine drains the queue through a simple valid/ready pop port. Software picks an active queue size and one of two admission modes through a small configuration port.

The queue is reachable through several page-sized windows that lie next to each other. Every 64-byte-aligned line inside any of these pages feeds the same queue. In shared mode a submitter that waits for an answer gets an accept or retry status one cycle after its write. In dedicated mode writes are fire-and-forget: a descriptor that finds the queue full is thrown away and only an internal drop counter records it.

Top module: `wqp_portal_top`

## Requirements
- R1: After reset the queue is empty (pop_valid low), rsp_valid is low, drop_count is zero, the mode is shared (cfg_dedicated 0) and the active size equals the physical depth DEPTH.
- R2: A write is a submit when its address is 64-byte aligned and lies in one of the PORTALS pages, where page k spans BASE_ADDR + k*PAGE_BYTES up to PAGE_BYTES bytes further. Every such line of every page feeds the same queue, and the full 512-bit descriptor is kept.
- R3: In shared mode a submit is admitted while the occupancy is below the active size. A write with wr_nonposted high gets rsp_valid high in the next cycle, with rsp_retry 0 on admission. A write with wr_nonposted low gets no response.
- R4: In shared mode a submit that finds occupancy equal to the active size, with no pop in the same cycle, is refused and leaves the queue unchanged. A write with wr_nonposted high then gets rsp_valid with rsp_retry 1 in the next cycle.
- R5: In dedicated mode (cfg_dedicated 1) no write ever gets a response. A submit that finds the queue at its active size is discarded, and drop_count rises by one in the next cycle.
- R6: pop_valid is high exactly while the queue holds a descriptor. pop_data shows the oldest one, and a cycle with pop_ready and pop_valid both high removes it, in arrival order.
- R7: A submit that arrives in the same cycle as a pop while the queue is at its active size is admitted.
- R8: A write with an address outside all pages, or not aligned to 64 bytes, does not change the queue or drop_count. In shared mode with wr_nonposted high it is answered with rsp_retry 1.
- R9: A configuration write (cfg_we) takes effect in the next cycle only if the queue is empty and no write is presented in the same cycle. Otherwise it is ignored. A size above DEPTH is clamped to DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A descriptor write is presented this cycle |
| wr_addr | input | ADDR_W (32) | Byte address of the write |
| wr_data | input | DATA_W (512) | The 64-byte descriptor |
| wr_nonposted | input | 1 | High when the submitter expects a status |
| rsp_valid | output | 1 | Status for the previous cycle's write |
| rsp_retry | output | 1 | 1 = refused, retry; 0 = accepted |
| pop_ready | input | 1 | Engine takes the head descriptor |
| pop_valid | output | 1 | Queue is non-empty |
| pop_data | output | DATA_W (512) | Oldest queued descriptor |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_size | input | $clog2(DEPTH+1) (5) | Requested active queue size |
| cfg_dedicated | input | 1 | 1 = dedicated mode, 0 = shared mode |
| drop_count | output | DROP_W (16) | Count of discarded dedicated-mode descriptors |

## Verification
The bench submits through many page and line combinations to show that every portal line aliases one ordered queue. It then fills the queue exactly to its active size and one past it, which separates an off-by-one in the occupancy compare from a correct bound. Misaligned, below-range and above-range addresses test the decoder edges. A full queue hit by a submit while a pop is under way shows whether a pop frees its slot within the same cycle. The same overflow pattern is run in both modes, so it tells a retry answer apart from a silent drop and its count. Configuration writes made while the queue holds data, and oversized requests, test the empty-only and clamping rules.

// File: rtl/wqp_pkg.sv
`timescale 1ns/1ps
package wqp_pkg;

   typedef enum logic {
      MODE_SHARED    = 1'b0,
      MODE_DEDICATED = 1'b1
   } wq_mode_e;

   typedef struct packed {
      logic push;
      logic refuse;
      logic drop;
   } verdict_t;

endpackage

// File: rtl/wqp_decode.sv
`timescale 1ns/1ps
module wqp_decode #(
   parameter int                ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR  = 32'h0004_0000,
   parameter int                PORTALS    = 4,
   parameter int                PAGE_BYTES = 4096,
   parameter int                LINE_BYTES = 64
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int LINE_LSB = $clog2(LINE_BYTES);
   localparam int EXT_W    = ADDR_W + 1;

   logic [EXT_W-1:0]   addr_ext;
   logic [PORTALS-1:0] page_hit;
   logic               aligned;

   assign addr_ext = {1'b0, addr};
   assign aligned  = (addr[LINE_LSB-1:0] == '0);

   // one window comparator per portal page
   for (genvar p = 0; p < PORTALS; p++) begin : g_page
      localparam logic [EXT_W-1:0] LO = EXT_W'(BASE_ADDR) + EXT_W'(p * PAGE_BYTES);
      localparam logic [EXT_W-1:0] HI = LO + EXT_W'(PAGE_BYTES);
      assign page_hit[p] = (addr_ext >= LO) && (addr_ext < HI);
   end

   assign hit = aligned && (|page_hit);

endmodule

// File: rtl/wqp_fifo.sv
`timescale 1ns/1ps
module wqp_fifo #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 512,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop_ready,
   output logic              pop_valid,
   output logic [DATA_W-1:0] pop_data,
   output logic              pop_fire,
   output logic [CNT_W-1:0]  count
);
   localparam int PTR_W = $clog2(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_ptr_nxt, rd_ptr_nxt;

   // pointer wrap: free wrap for powers of two, compare otherwise
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
      assign wr_ptr_nxt = wr_ptr + PTR_W'(1);
      assign rd_ptr_nxt = rd_ptr + PTR_W'(1);
   end else begin : g_wrap_cmp
      assign wr_ptr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_ptr_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
   end

   assign pop_valid = (count != '0);
   assign pop_fire  = pop_valid && pop_ready;
   assign pop_data  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push)     wr_ptr <= wr_ptr_nxt;
         if (pop_fire) rd_ptr <= rd_ptr_nxt;
         case ({push, pop_fire})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   // R7: a write into a physically full store needs a pop in the same cycle
   fifo_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> ((count < CNT_W'(DEPTH)) || pop_fire));

   // R6: one pop lowers the occupancy by exactly one when nothing is pushed
   pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_fire && !push) |=> (count == $past(count) - CNT_W'(1)));

endmodule

// File: rtl/wqp_admit.sv
`timescale 1ns/1ps
module wqp_admit
   import wqp_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int CNT_W  = $clog2(DEPTH + 1),
   parameter int DROP_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic              hit,
   input  logic              nonposted,
   input  logic              pop_fire,
   input  logic [CNT_W-1:0]  count,
   input  logic              cfg_we,
   input  logic [CNT_W-1:0]  cfg_size,
   input  logic              cfg_dedicated,
   output logic              push,
   output logic              rsp_valid,
   output logic              rsp_retry,
   output logic [DROP_W-1:0] drop_count
);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   logic [CNT_W-1:0] size_q;
   wq_mode_e         mode_q;
   verdict_t         vd;
   logic             room;
   logic             cfg_take;
   logic [CNT_W-1:0] size_clamped;

   assign room = (count < size_q) || pop_fire;

   always_comb begin
      vd.push   = wr_valid && hit && room;
      vd.refuse = wr_valid && !vd.push;
      vd.drop   = wr_valid && hit && !room && (mode_q == MODE_DEDICATED);
   end

   assign push         = vd.push;
   assign cfg_take     = cfg_we && (count == '0) && !wr_valid;
   assign size_clamped = (cfg_size > DEPTH_C) ? DEPTH_C : cfg_size;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         size_q     <= DEPTH_C;
         mode_q     <= MODE_SHARED;
         rsp_valid  <= 1'b0;
         rsp_retry  <= 1'b0;
         drop_count <= '0;
      end else begin
         if (cfg_take) begin
            size_q <= size_clamped;
            mode_q <= wq_mode_e'(cfg_dedicated);
         end
         rsp_valid <= wr_valid && nonposted && (mode_q == MODE_SHARED);
         rsp_retry <= vd.refuse;
         if (vd.drop) drop_count <= drop_count + DROP_W'(1);
      end
   end

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= size_q);

   // R5
   ded_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_DEDICATED) |=> !rsp_valid);

   // R5
   drop_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_count != $past(drop_count)) |-> ($past(mode_q) == MODE_DEDICATED));

   // R9
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count != '0) |=> ($stable(size_q) && $stable(mode_q)));

   // R9
   size_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      size_q <= DEPTH_C);

endmodule

// File: rtl/wqp_portal_top.sv
`timescale 1ns/1ps
module wqp_portal_top
   import wqp_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                DATA_W     = 512,
   parameter int                DEPTH      = 16,
   parameter int                PORTALS    = 4,
   parameter int                PAGE_BYTES = 4096,
   parameter int                LINE_BYTES = 64,
   parameter logic [ADDR_W-1:0] BASE_ADDR  = 32'h0004_0000,
   parameter int                DROP_W     = 16,
   localparam int               CNT_W      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_nonposted,
   output logic              rsp_valid,
   output logic              rsp_retry,
   input  logic              pop_ready,
   output logic              pop_valid,
   output logic [DATA_W-1:0] pop_data,
   input  logic              cfg_we,
   input  logic [CNT_W-1:0]  cfg_size,
   input  logic              cfg_dedicated,
   output logic [DROP_W-1:0] drop_count
);
   initial begin
      param_width_chk: assert (DATA_W == 8 * LINE_BYTES)
         else $error("descriptor width must equal one line");
      param_depth_chk: assert (DEPTH >= 2)
         else $error("queue depth must be at least two");
      param_page_chk: assert ((PAGE_BYTES % LINE_BYTES) == 0 && PAGE_BYTES >= LINE_BYTES)
         else $error("page must hold whole lines");
      param_line_chk: assert ((LINE_BYTES & (LINE_BYTES - 1)) == 0 && LINE_BYTES >= 2)
         else $error("line size must be a power of two");
      param_base_chk: assert ((BASE_ADDR % PAGE_BYTES) == 0)
         else $error("base must be page aligned");
      param_span_chk: assert (PORTALS >= 1 && DROP_W >= 1)
         else $error("need at least one portal and a drop counter bit");
   end

   logic             hit;
   logic             push;
   logic             pop_fire;
   logic [CNT_W-1:0] count;

   wqp_decode #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR),
      .PORTALS   (PORTALS),
      .PAGE_BYTES(PAGE_BYTES),
      .LINE_BYTES(LINE_BYTES)
   ) decode_i (
      .addr(wr_addr),
      .hit (hit)
   );

   wqp_admit #(
      .DEPTH (DEPTH),
      .CNT_W (CNT_W),
      .DROP_W(DROP_W)
   ) admit_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_valid     (wr_valid),
      .hit          (hit),
      .nonposted    (wr_nonposted),
      .pop_fire     (pop_fire),
      .count        (count),
      .cfg_we       (cfg_we),
      .cfg_size     (cfg_size),
      .cfg_dedicated(cfg_dedicated),
      .push         (push),
      .rsp_valid    (rsp_valid),
      .rsp_retry    (rsp_retry),
      .drop_count   (drop_count)
   );

   wqp_fifo #(
      .DEPTH (DEPTH),
      .DATA_W(DATA_W),
      .CNT_W (CNT_W)
   ) fifo_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .push_data(wr_data),
      .pop_ready(pop_ready),
      .pop_valid(pop_valid),
      .pop_data (pop_data),
      .pop_fire (pop_fire),
      .count    (count)
   );

   // R3
   rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(wr_valid && wr_nonposted));

   // R8
   miss_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !hit) |-> !push);

endmodule

// File: tb/wqp_portal_top_tb_top.sv
`timescale 1ns/1ps
module wqp_portal_top_tb_top;
   localparam int          DEPTH = 16;
   localparam logic [31:0] BASE  = 32'h0004_0000;
   localparam int          PAGE  = 4096;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_valid = 1'b0;
   logic [31:0]  wr_addr = '0;
   logic [511:0] wr_data = '0;
   logic         wr_nonposted = 1'b0;
   logic         rsp_valid, rsp_retry;
   logic         pop_ready = 1'b0;
   logic         pop_valid;
   logic [511:0] pop_data;
   logic         cfg_we = 1'b0;
   logic [4:0]   cfg_size = '0;
   logic         cfg_dedicated = 1'b0;
   logic [15:0]  drop_count;

   int checks = 0;
   int errors = 0;
   int model_count = 0;
   int model_size = DEPTH;
   bit model_ded = 1'b0;
   int model_drop = 0;
   int seq = 0;
   logic [511:0] exp_q[$];

   always #4 clk = ~clk;

   wqp_portal_top dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_nonposted(wr_nonposted),
      .rsp_valid(rsp_valid), .rsp_retry(rsp_retry),
      .pop_ready(pop_ready), .pop_valid(pop_valid), .pop_data(pop_data),
      .cfg_we(cfg_we), .cfg_size(cfg_size), .cfg_dedicated(cfg_dedicated),
      .drop_count(drop_count)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: compares every pop against the scoreboard
   always @(negedge clk) begin
      if (rst_n && pop_ready && pop_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R6", "unexpected pop", pop_data[63:0], 64'h0);
         end else begin
            logic [511:0] e;
            e = exp_q.pop_front();
            chk(pop_data === e, "R6", "pop data", pop_data[63:0], e[63:0]);
            model_count--;
         end
      end
   end

   task automatic submit(input logic [31:0] addr, input bit np, input bit exp_hit,
                         input bit with_pop, input string req);
      logic [511:0] d;
      bit adm;
      seq++;
      d = {16{32'hC300_0000 | 32'(seq)}};
      d[511:480] = 32'(seq) ^ 32'h5A5A_0000;
      @(posedge clk); #1;
      adm = exp_hit && ((model_count < model_size) || (with_pop && model_count > 0));
      wr_valid = 1'b1; wr_addr = addr; wr_data = d; wr_nonposted = np;
      if (with_pop) pop_ready = 1'b1;
      if (adm) begin exp_q.push_back(d); model_count++; end
      if (model_ded && exp_hit && !adm) model_drop++;
      @(posedge clk); #1;
      wr_valid = 1'b0;
      if (with_pop) pop_ready = 1'b0;
      if (np && !model_ded) begin
         chk(rsp_valid === 1'b1, req, "rsp_valid", 64'(rsp_valid), 64'd1);
         chk(rsp_retry === !adm, req, "rsp_retry", 64'(rsp_retry), 64'(!adm));
      end else begin
         chk(rsp_valid === 1'b0, req, "rsp_valid", 64'(rsp_valid), 64'd0);
      end
      chk(drop_count === 16'(model_drop), req, "drop_count", 64'(drop_count), 64'(model_drop));
   endtask

   task automatic config_q(input int size, input bit ded);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_size = 5'(size); cfg_dedicated = ded;
      if (model_count == 0) begin
         model_size = (size > DEPTH) ? DEPTH : size;
         model_ded  = ded;
      end
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic drain(input string req);
      @(posedge clk); #1;
      pop_ready = 1'b1;
      for (int n = 0; n < 40; n++) begin
         @(posedge clk); #1;
         if (model_count == 0) break;
      end
      pop_ready = 1'b0;
      chk(pop_valid === 1'b0, req, "empty after drain", 64'(pop_valid), 64'd0);
      chk(exp_q.size() == 0, req, "scoreboard empty", 64'(exp_q.size()), 64'd0);
   endtask

   function automatic logic [31:0] line_addr(input int page, input int line);
      return BASE + 32'(page * PAGE) + 32'(line * 64);
   endfunction

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(pop_valid === 1'b0, "R1", "pop_valid", 64'(pop_valid), 64'd0);
      chk(rsp_valid === 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 64'd0);
      chk(drop_count === 16'd0, "R1", "drop_count", 64'(drop_count), 64'd0);

      // R2 R3: fill the default size through all portals and many lines
      for (int i = 0; i < DEPTH; i++)
         submit(line_addr(i % 4, (i * 7) % 64), 1'b1, 1'b1, 1'b0, "R3");
      // R1 R4: default size is DEPTH, one more is refused
      submit(line_addr(3, 63), 1'b1, 1'b1, 1'b0, "R4");
      drain("R6");

      // R8: misaligned, above the last page, below the first page
      submit(BASE + 32'd32, 1'b1, 1'b0, 1'b0, "R8");
      submit(line_addr(4, 0), 1'b1, 1'b0, 1'b0, "R8");
      submit(BASE - 32'd64, 1'b1, 1'b0, 1'b0, "R8");
      chk(pop_valid === 1'b0, "R8", "queue untouched", 64'(pop_valid), 64'd0);

      // R9: size 4, then a resize while non-empty is ignored
      config_q(4, 1'b0);
      submit(line_addr(0, 1), 1'b1, 1'b1, 1'b0, "R3");
      config_q(2, 1'b0);
      for (int i = 0; i < 3; i++)
         submit(line_addr(1, 2 + i), 1'b1, 1'b1, 1'b0, "R9");
      submit(line_addr(2, 9), 1'b1, 1'b1, 1'b0, "R4");
      // R7: full queue, pop in the same cycle as the submit
      submit(line_addr(2, 10), 1'b1, 1'b1, 1'b1, "R7");
      // R3: posted write in shared mode gets no answer
      drain("R6");
      submit(line_addr(0, 0), 1'b0, 1'b1, 1'b0, "R3");
      drain("R6");

      // R5: dedicated mode, size 2
      config_q(2, 1'b1);
      submit(line_addr(0, 5), 1'b0, 1'b1, 1'b0, "R5");
      submit(line_addr(3, 6), 1'b0, 1'b1, 1'b0, "R5");
      submit(line_addr(1, 7), 1'b0, 1'b1, 1'b0, "R5");
      submit(line_addr(2, 8), 1'b1, 1'b1, 1'b0, "R5");
      submit(BASE + 32'd8, 1'b0, 1'b0, 1'b0, "R8");
      chk(drop_count === 16'd2, "R5", "drops total", 64'(drop_count), 64'd2);
      drain("R6");

      // R9: oversized request clamps to DEPTH
      config_q(20, 1'b0);
      for (int i = 0; i < DEPTH; i++)
         submit(line_addr(i % 4, 63 - i), 1'b1, 1'b1, 1'b0, "R9");
      submit(line_addr(0, 30), 1'b1, 1'b1, 1'b0, "R9");
      drain("R6");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 20000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule